// File: doc/BRIEF.md
# Outbound Direct Address Window Translator

This block sits on the outbound path from the internal bus towards two PCI-side master ports. It looks at each internal-bus request (address, command, write data) and decides whether the request belongs to a fixed direct-mapped window. The window spans internal addresses 0x0000_2000 up to 0x7FFF_FFFF. The lowest 8 KiB are reserved for local RAM and registers, so they are never claimed.

A claimed request with a plain memory read or memory write command is captured into a one-entry output register. It then leaves on either the primary or the secondary channel, under a valid/ready handshake. The channel is picked by a control bit. A second control bit can force address bit 31 high, which moves the window onto the upper half of PCI memory space. All other address bits, the command and the write data pass through unchanged.

A claimed request with any other command is dropped and gives a one-cycle reject pulse. A request outside the window, or any request while the window is disabled, gives a one-cycle not-claimed pulse so that another decoder can take it.

Top module: `dawin_xlate`

## Requirements
- R1: After reset the control register is zero: the window is disabled, the primary channel is selected and there is no translation. Both output channels are idle and both pulse outputs are low.
- R2: The window covers internal addresses 0x0000_2000 to 0x7FFF_FFFF, bounds included. Addresses 0x0000_0000 to 0x0000_1FFF and 0x8000_0000 and above are never forwarded and give the not-claimed pulse.
- R3: While control bit 0 (window enable) is 0, every accepted request gives the not-claimed pulse and nothing is forwarded.
- R4: While control bit 2 (upper translate) is 0, the forwarded address equals the request address. While it is 1, the forwarded address is the request address with bit 31 set and all other bits unchanged.
- R5: Control bit 1 (secondary select) steers window traffic. When it is 0, traffic goes to the primary channel. When it is 1, traffic goes to the secondary channel. The unselected channel stays idle.
- R6: Only command 4'h6 (memory read) and command 4'h7 (memory write) are forwarded. Any other command to an address in an enabled window is dropped and gives the reject pulse. The forwarded command and write data equal those of the request.
- R7: A forwarded request appears on its channel one clock after acceptance. Valid, address, command and data stay stable until the handshake completes with ready high.
- R8: For a request that would be forwarded, req_ready is high only when the selected channel's output register is empty or is being drained in that cycle. For a request that would not be forwarded, req_ready is high.
- R9: The channel choice and the translation setting are captured when a request is accepted. A later control write does not change a request waiting on a channel.
- R10: The not-claimed and reject pulses are registered. Each lasts one clock per rejected or unclaimed request, and the two are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | Control register write strobe |
| cfg_wr_data | input | 3 | bit0 enable, bit1 secondary select, bit2 upper translate |
| req_valid | input | 1 | Internal-bus request valid |
| req_ready | output | 1 | Request may be accepted |
| req_addr | input | 32 | Request address |
| req_cmd | input | 4 | Request command code |
| req_wdata | input | 32 | Request write data |
| pri_valid | output | 1 | Primary channel request valid |
| pri_ready | input | 1 | Primary channel ready |
| pri_addr | output | 32 | Primary channel address |
| pri_cmd | output | 4 | Primary channel command |
| pri_wdata | output | 32 | Primary channel write data |
| sec_valid | output | 1 | Secondary channel request valid |
| sec_ready | input | 1 | Secondary channel ready |
| sec_addr | output | 32 | Secondary channel address |
| sec_cmd | output | 4 | Secondary channel command |
| sec_wdata | output | 32 | Secondary channel write data |
| unclaimed | output | 1 | One-cycle pulse: request not taken by this window |
| reject | output | 1 | One-cycle pulse: in-window request with unsupported command |

## Verification
A control register holding the wrong bit sends the very next accepted request to the wrong channel, or with the wrong bit 31, or turns it into a not-claimed pulse. This is visible one clock after acceptance. An output register that loses or overwrites its content shows up while the channel is stalled: the held address changes, or req_ready rises for a second request to the full channel. A decode error at the window edges or in the command filter shows as the wrong pulse, or a missing one, one clock after the boundary request.

// File: rtl/dawin_pkg.sv
package dawin_pkg;

    localparam int CMD_W = 4;

    localparam logic [CMD_W-1:0] CMD_MEM_RD = 4'h6;
    localparam logic [CMD_W-1:0] CMD_MEM_WR = 4'h7;

    // bit2 upper translate, bit1 secondary select, bit0 enable
    typedef struct packed {
        logic upper;
        logic second;
        logic en;
    } cfg_t;

    typedef enum logic [1:0] {
        CLS_MISS = 2'd0,
        CLS_FWD  = 2'd1,
        CLS_REJ  = 2'd2
    } cls_e;

endpackage

// File: rtl/dawin_cfg.sv
module dawin_cfg
    import dawin_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [2:0] wr_data,
    output cfg_t       cfg_o
);

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            cfg_d = cfg_t'(wr_data);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg_o = cfg_q;

endmodule

// File: rtl/dawin_decode.sv
module dawin_decode
    import dawin_pkg::*;
#(
    parameter int              ADDR_W = 32,
    parameter logic [ADDR_W-1:0] WIN_LO = 32'h0000_2000,
    parameter logic [ADDR_W-1:0] WIN_HI = 32'h7FFF_FFFF
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [CMD_W-1:0]  cmd_i,
    input  cfg_t              cfg_i,
    output cls_e              cls_o,
    output logic [ADDR_W-1:0] xaddr_o,
    output logic              to_sec_o
);

    localparam int TOP_BIT = ADDR_W - 1;

    logic in_win;
    logic cmd_ok;

    always_comb begin
        in_win = (addr_i >= WIN_LO) && (addr_i <= WIN_HI);
        cmd_ok = (cmd_i == CMD_MEM_RD) || (cmd_i == CMD_MEM_WR);

        if (!cfg_i.en || !in_win) begin
            cls_o = CLS_MISS;
        end else if (cmd_ok) begin
            cls_o = CLS_FWD;
        end else begin
            cls_o = CLS_REJ;
        end

        xaddr_o          = addr_i;
        xaddr_o[TOP_BIT] = addr_i[TOP_BIT] | cfg_i.upper;
        to_sec_o         = cfg_i.second;
    end

endmodule

// File: rtl/dawin_slot.sv
module dawin_slot
    import dawin_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [CMD_W-1:0]  cmd_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              free_o,
    output logic              valid_o,
    input  logic              ready_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [CMD_W-1:0]  cmd_o,
    output logic [DATA_W-1:0] data_o
);

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
        logic [CMD_W-1:0]  cmd;
        logic [DATA_W-1:0] data;
    } slot_t;

    slot_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.valid = 1'b1;
            st_d.addr  = addr_i;
            st_d.cmd   = cmd_i;
            st_d.data  = data_i;
        end else if (ready_i) begin
            st_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign free_o  = !st_q.valid || ready_i;
    assign valid_o = st_q.valid;
    assign addr_o  = st_q.addr;
    assign cmd_o   = st_q.cmd;
    assign data_o  = st_q.data;

endmodule

// File: rtl/dawin_xlate.sv
module dawin_xlate
    import dawin_pkg::*;
#(
    parameter int                ADDR_W = 32,
    parameter int                DATA_W = 32,
    parameter logic [ADDR_W-1:0] WIN_LO = 32'h0000_2000,
    parameter logic [ADDR_W-1:0] WIN_HI = 32'h7FFF_FFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [2:0]        cfg_wr_data,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [CMD_W-1:0]  req_cmd,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              pri_valid,
    input  logic              pri_ready,
    output logic [ADDR_W-1:0] pri_addr,
    output logic [CMD_W-1:0]  pri_cmd,
    output logic [DATA_W-1:0] pri_wdata,
    output logic              sec_valid,
    input  logic              sec_ready,
    output logic [ADDR_W-1:0] sec_addr,
    output logic [CMD_W-1:0]  sec_cmd,
    output logic [DATA_W-1:0] sec_wdata,
    output logic              unclaimed,
    output logic              reject
);

    localparam int NPORT = 2;

    typedef struct packed {
        logic unclaimed;
        logic reject;
    } pulse_t;

    cfg_t              cfg_q;
    cls_e              cls;
    logic [ADDR_W-1:0] xaddr;
    logic              to_sec;
    logic              accept;

    logic [NPORT-1:0]  slot_free;
    logic [NPORT-1:0]  slot_load;
    logic [NPORT-1:0]  slot_valid;
    logic [NPORT-1:0]  slot_ready;
    logic [ADDR_W-1:0] slot_addr  [NPORT];
    logic [CMD_W-1:0]  slot_cmd   [NPORT];
    logic [DATA_W-1:0] slot_data  [NPORT];

    pulse_t pulse_d, pulse_q;

    dawin_cfg u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr_en),
        .wr_data (cfg_wr_data),
        .cfg_o   (cfg_q)
    );

    dawin_decode #(
        .ADDR_W (ADDR_W),
        .WIN_LO (WIN_LO),
        .WIN_HI (WIN_HI)
    ) u_dec (
        .addr_i   (req_addr),
        .cmd_i    (req_cmd),
        .cfg_i    (cfg_q),
        .cls_o    (cls),
        .xaddr_o  (xaddr),
        .to_sec_o (to_sec)
    );

    assign slot_ready = {sec_ready, pri_ready};

    always_comb begin
        req_ready = (cls == CLS_FWD) ? slot_free[to_sec] : 1'b1;
        accept    = req_valid && req_ready;
        for (int p = 0; p < NPORT; p++) begin
            slot_load[p] = accept && (cls == CLS_FWD) && (int'(to_sec) == p);
        end
    end

    for (genvar g = 0; g < NPORT; g++) begin : g_slot
        dawin_slot #(
            .ADDR_W (ADDR_W),
            .DATA_W (DATA_W)
        ) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .load_i  (slot_load[g]),
            .addr_i  (xaddr),
            .cmd_i   (req_cmd),
            .data_i  (req_wdata),
            .free_o  (slot_free[g]),
            .valid_o (slot_valid[g]),
            .ready_i (slot_ready[g]),
            .addr_o  (slot_addr[g]),
            .cmd_o   (slot_cmd[g]),
            .data_o  (slot_data[g])
        );
    end

    always_comb begin
        pulse_d           = '0;
        pulse_d.unclaimed = accept && (cls == CLS_MISS);
        pulse_d.reject    = accept && (cls == CLS_REJ);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pulse_q <= '0;
        end else begin
            pulse_q <= pulse_d;
        end
    end

    assign unclaimed = pulse_q.unclaimed;
    assign reject    = pulse_q.reject;

    assign pri_valid = slot_valid[0];
    assign pri_addr  = slot_addr[0];
    assign pri_cmd   = slot_cmd[0];
    assign pri_wdata = slot_data[0];
    assign sec_valid = slot_valid[1];
    assign sec_addr  = slot_addr[1];
    assign sec_cmd   = slot_cmd[1];
    assign sec_wdata = slot_data[1];

endmodule

// File: rtl/dawin_xlate_chk.sv
module dawin_xlate_chk
    import dawin_pkg::*;
#(
    parameter int                ADDR_W = 32,
    parameter logic [ADDR_W-1:0] WIN_LO = 32'h0000_2000
) (
    input logic              clk,
    input logic              rst_n,
    input cfg_t              cfg_q,
    input logic              req_valid,
    input logic              req_ready,
    input logic              pri_valid,
    input logic              pri_ready,
    input logic [ADDR_W-1:0] pri_addr,
    input logic [CMD_W-1:0]  pri_cmd,
    input logic              sec_valid,
    input logic              sec_ready,
    input logic [ADDR_W-1:0] sec_addr,
    input logic [CMD_W-1:0]  sec_cmd,
    input logic              unclaimed,
    input logic              reject
);

    assert_dis_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !cfg_q.en) |=> unclaimed);

    assert_win_pri_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pri_valid |-> (pri_addr[ADDR_W-2:0] >= WIN_LO[ADDR_W-2:0]));

    assert_win_sec_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sec_valid |-> (sec_addr[ADDR_W-2:0] >= WIN_LO[ADDR_W-2:0]));

    assert_cmd_pri_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pri_valid |-> (pri_cmd == CMD_MEM_RD || pri_cmd == CMD_MEM_WR));

    assert_cmd_sec_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sec_valid |-> (sec_cmd == CMD_MEM_RD || sec_cmd == CMD_MEM_WR));

    assert_hold_pri_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pri_valid && !pri_ready) |=> (pri_valid && $stable(pri_addr) && $stable(pri_cmd)));

    assert_hold_sec_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_valid && !sec_ready) |=> (sec_valid && $stable(sec_addr) && $stable(sec_cmd)));

    assert_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(unclaimed && reject));

endmodule

bind dawin_xlate dawin_xlate_chk #(
    .ADDR_W (ADDR_W),
    .WIN_LO (WIN_LO)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_q     (cfg_q),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .pri_valid (pri_valid),
    .pri_ready (pri_ready),
    .pri_addr  (pri_addr),
    .pri_cmd   (pri_cmd),
    .sec_valid (sec_valid),
    .sec_ready (sec_ready),
    .sec_addr  (sec_addr),
    .sec_cmd   (sec_cmd),
    .unclaimed (unclaimed),
    .reject    (reject)
);

// File: tb/dawin_xlate_tb_top.sv
module dawin_xlate_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [2:0]  cfg_wr_data = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic [3:0]  req_cmd = '0;
    logic [31:0] req_wdata = '0;
    logic        pri_valid, sec_valid, unclaimed, reject;
    logic        pri_ready = 1'b1;
    logic        sec_ready = 1'b1;
    logic [31:0] pri_addr, sec_addr, pri_wdata, sec_wdata;
    logic [3:0]  pri_cmd, sec_cmd;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    dawin_xlate dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_wr_en   (cfg_wr_en),
        .cfg_wr_data (cfg_wr_data),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .req_addr    (req_addr),
        .req_cmd     (req_cmd),
        .req_wdata   (req_wdata),
        .pri_valid   (pri_valid),
        .pri_ready   (pri_ready),
        .pri_addr    (pri_addr),
        .pri_cmd     (pri_cmd),
        .pri_wdata   (pri_wdata),
        .sec_valid   (sec_valid),
        .sec_ready   (sec_ready),
        .sec_addr    (sec_addr),
        .sec_cmd     (sec_cmd),
        .sec_wdata   (sec_wdata),
        .unclaimed   (unclaimed),
        .reject      (reject)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [2:0] v);
        @(negedge clk);
        cfg_wr_en = 1'b1;
        cfg_wr_data = v;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    // drive one request; returns at the negedge after acceptance
    task automatic send(input logic [31:0] a, input logic [3:0] c, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        req_cmd   = c;
        req_wdata = d;
        #1;
        while (!req_ready) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        req_valid = 1'b0;
        #1;
    endtask

    // expected outcome: 0 miss, 1 primary, 2 secondary, 3 reject
    task automatic expect_out(input string tag, input int kind, input logic [31:0] ea);
        logic [3:0] got;
        got = {reject, unclaimed, sec_valid, pri_valid};
        case (kind)
            0: check(got == 4'b0100, tag, {28'd0, got}, 32'h4);
            1: begin
                check(got == 4'b0001, tag, {28'd0, got}, 32'h1);
                check(pri_addr == ea, tag, pri_addr, ea);
            end
            2: begin
                check(got == 4'b0010, tag, {28'd0, got}, 32'h2);
                check(sec_addr == ea, tag, sec_addr, ea);
            end
            default: check(got == 4'b1000, tag, {28'd0, got}, 32'h8);
        endcase
    endtask

    task automatic t_reset;
        check(!pri_valid && !sec_valid, "R1 channels idle", {30'd0, sec_valid, pri_valid}, 32'h0);
        check(!unclaimed && !reject, "R1 pulses low", {30'd0, reject, unclaimed}, 32'h0);
        send(32'h4000_0000, 4'h7, 32'h1);
        expect_out("R1 reset disabled window", 0, 32'h0);
    endtask

    task automatic t_disable;
        cfg_write(3'b110);
        send(32'h4000_0000, 4'h6, 32'h0);
        expect_out("R3 enable clear", 0, 32'h0);
    endtask

    task automatic t_bounds;
        cfg_write(3'b001);
        send(32'h0000_1FFF, 4'h7, 32'h0);
        expect_out("R2 below low edge", 0, 32'h0);
        send(32'h0000_0000, 4'h6, 32'h0);
        expect_out("R2 zero", 0, 32'h0);
        send(32'h0000_2000, 4'h7, 32'h0);
        expect_out("R2 low edge", 1, 32'h0000_2000);
        send(32'h7FFF_FFFC, 4'h6, 32'h0);
        expect_out("R2 near top", 1, 32'h7FFF_FFFC);
        send(32'h7FFF_FFFF, 4'h6, 32'h0);
        expect_out("R2 top edge", 1, 32'h7FFF_FFFF);
        send(32'h8000_0000, 4'h7, 32'h0);
        expect_out("R2 above top", 0, 32'h0);
        send(32'hFFFF_FFFF, 4'h7, 32'h0);
        expect_out("R2 max", 0, 32'h0);
    endtask

    task automatic t_xlate;
        cfg_write(3'b101);
        send(32'h6000_1008, 4'h7, 32'hA5A5_0001);
        expect_out("R4 translate set", 1, 32'hE000_1008);
        check(pri_wdata == 32'hA5A5_0001, "R6 data pass", pri_wdata, 32'hA5A5_0001);
        cfg_write(3'b001);
        send(32'h6000_1008, 4'h7, 32'h0);
        expect_out("R4 translate clear", 1, 32'h6000_1008);
    endtask

    task automatic t_steer;
        cfg_write(3'b011);
        send(32'h1234_5678, 4'h6, 32'h0);
        expect_out("R5 secondary", 2, 32'h1234_5678);
        check(sec_cmd == 4'h6, "R6 cmd pass", {28'd0, sec_cmd}, 32'h6);
        cfg_write(3'b111);
        send(32'h0000_2004, 4'h7, 32'h0);
        expect_out("R5 secondary translated", 2, 32'h8000_2004);
        cfg_write(3'b001);
        send(32'h0000_2004, 4'h7, 32'h0);
        expect_out("R5 back to primary", 1, 32'h0000_2004);
    endtask

    task automatic t_cmd;
        logic [3:0] bad [5] = '{4'h2, 4'h3, 4'hD, 4'hF, 4'h0};
        cfg_write(3'b001);
        foreach (bad[i]) begin
            send(32'h3000_0000, bad[i], 32'h0);
            expect_out("R6 unsupported command", 3, 32'h0);
        end
        @(negedge clk);
        check(!reject && !unclaimed, "R10 one-cycle pulse", {30'd0, reject, unclaimed}, 32'h0);
        send(32'h3000_0000, 4'h6, 32'h0);
        expect_out("R6 memory read", 1, 32'h3000_0000);
        check(pri_cmd == 4'h6, "R6 read cmd", {28'd0, pri_cmd}, 32'h6);
    endtask

    task automatic t_stall;
        cfg_write(3'b001);
        pri_ready = 1'b0;
        send(32'h1000_0000, 4'h7, 32'h0);
        expect_out("R7 appears next cycle", 1, 32'h1000_0000);
        repeat (3) @(negedge clk);
        #1;
        check(pri_valid && pri_addr == 32'h1000_0000, "R7 held while stalled", pri_addr, 32'h1000_0000);
        cfg_write(3'b111);
        #1;
        check(pri_addr == 32'h1000_0000, "R9 in-flight unaffected", pri_addr, 32'h1000_0000);
        check(pri_valid && !sec_valid, "R9 channel kept", {30'd0, sec_valid, pri_valid}, 32'h1);
        cfg_write(3'b001);
        req_addr = 32'h2000_0000;
        req_cmd  = 4'h7;
        #1;
        check(!req_ready, "R8 full channel blocks", {31'd0, req_ready}, 32'h0);
        req_addr = 32'h9000_0000;
        #1;
        check(req_ready, "R8 miss always ready", {31'd0, req_ready}, 32'h1);
        pri_ready = 1'b1;
        #1;
        req_addr = 32'h2000_0000;
        #1;
        check(req_ready, "R8 draining channel ready", {31'd0, req_ready}, 32'h1);
        @(negedge clk);
        #1;
        check(!pri_valid, "R7 drained after ready", {31'd0, pri_valid}, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        t_reset();
        t_disable();
        t_bounds();
        t_xlate();
        t_steer();
        t_cmd();
        t_stall();
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule